// File: doc/BRIEF.md
# Fault-first vector load sequencer

This block executes one vector load at a time. A start pulse captures a vector length, a per-element enable mask, a source base register index, a destination base register index and a 32-bit offset. The sequencer then walks the elements one per step in rising index order. For each enabled element it reads an address register, adds the offset, sends one request to the memory port and writes the returned word into the matching destination register.

The memory port can report a fault with its response. A fault on the first element raises an exception. A fault on any later element shortens the reported vector length to that element's index and ends the instruction cleanly, so that the caller can resume from there. A register range that would run past the end of the register file is rejected as an illegal instruction before any memory traffic. The register file and a small memory model sit inside the block. The register file has a preload write port and an inspection read port that serve the surrounding pipeline.

Top module: `vldq_ffload`

## Requirements
- R1: Elements are visited in ascending index order from 0 to VL-1. An enabled element i that does not fault writes its loaded word to register rt+i, and a completed instruction reports vl_out equal to the requested VL with exc and illegal both 0.
- R2: An element whose mask bit (bit i of mask_in for element i) is 0 makes no memory request and leaves register rt+i unchanged. A faulting address on a masked-off element therefore has no effect.
- R3: The address of element i is the 32-bit sum, wrapping modulo 2^32, of the contents of register ra+i and imm_in.
- R4: A fault on element index 0 sets exc to 1, leaves every register unchanged and reports vl_out equal to the requested VL.
- R5: A fault on element i with i > 0 reports vl_out = i with exc 0. Elements below i keep their loaded values and no register at index i or above is written. The index is the raw element index, so a masked-off element 0 followed by a fault on element 1 gives vl_out = 1.
- R6: The instruction is illegal when VL is 0, VL is above 16, ra+VL exceeds 32, or rt+VL exceeds 32. An illegal instruction sets illegal to 1, reports vl_out equal to the requested VL, makes no memory request and writes no register.
- R7: done is high for exactly one cycle per accepted start. Let E be the number of masked-off elements visited plus two for each element that issues a request. done rises on the edge that accepts start for an illegal instruction, E edges after it when a fault occurs, and E+1 edges after it on completion.
- R8: The memory model returns the bitwise inverse of the request address. It flags a fault when the address is at or above FAULT_BASE (default 0x0001_0000), and it holds at most one request in flight.
- R9: While busy is 1, start pulses and preload writes are ignored. The running instruction's result and the register contents are unaffected.
- R10: After reset, busy, done, exc and illegal are 0, vl_out is 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| vl_in | input | 5 | Requested vector length |
| mask_in | input | 16 | Per-element enable mask |
| ra_in | input | 5 | Base index of the address registers |
| rt_in | input | 5 | Base index of the destination registers |
| imm_in | input | 32 | Offset added to every address |
| pre_we | input | 1 | Preload write enable (idle only) |
| pre_idx | input | 5 | Preload register index |
| pre_data | input | 32 | Preload write data |
| rd_idx | input | 5 | Inspection read index |
| rd_data | output | 32 | Inspection read data (combinational) |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | 5 | Final vector length |
| exc | output | 1 | Exception on element 0 |
| illegal | output | 1 | Illegal instruction |

## Verification
The result flags and vl_out become valid together with the done pulse. For each case the bench derives its expected arrival edge from the mask and the fault position: the accepting edge itself for an illegal case, E edges later for a fault and E+1 edges later for a completion. The bench drives inputs on falling edges and counts falling edges from the accepting edge until done is seen. It compares that count exactly with the expected latency, then checks on the next falling edge that done has dropped. Register contents are read through the combinational inspection port only after done, so every result is sampled half a cycle after the edge that produced it.

// File: rtl/vldq_pkg.sv
// Package: shared defaults and the sequencer state type.
// Assumes: all modules of the fault-first load block import it.
package vldq_pkg;
    localparam int NREG_DEF  = 32;
    localparam int XLEN_DEF  = 32;
    localparam int MAXVL_DEF = 16;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STEP,
        SQ_WAIT,
        SQ_FIN
    } seq_state_e;
endpackage

// File: rtl/vldq_regfile.sv
// Register file: NREG words of XLEN bits, one write port and two
// combinational read ports. Cleared to zero by reset.
// Assumes: the caller arbitrates the single write port.
module vldq_regfile #(
    parameter int NREG = vldq_pkg::NREG_DEF,
    parameter int XLEN = vldq_pkg::XLEN_DEF,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    output logic [XLEN-1:0]   rdata_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] regs_q [NREG];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_word
            // Purpose: clear one word on reset, update it on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else if (we && (waddr == RIDX_W'(g))) begin
                    regs_q[g] <= wdata;
                end
            end
        end
    endgenerate

    // Purpose: asynchronous read for the sequencer and the inspection port.
    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/vldq_mem_model.sv
// Memory model: accepts one request at a time over valid/ready and
// answers on the next cycle with inverted-address data and a fault flag
// for addresses at or above FAULT_BASE.
// Assumes: the requester takes the response in the cycle it appears.
module vldq_mem_model #(
    parameter int XLEN = vldq_pkg::XLEN_DEF,
    parameter logic [XLEN-1:0] FAULT_BASE = 'h0001_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XLEN-1:0] req_addr,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_data,
    output logic            rsp_fault
);
    logic            pend_q;
    logic [XLEN-1:0] data_q;
    logic            fault_q;

    // Purpose: only one request may be in flight.
    assign req_ready = !pend_q;

    // Purpose: capture an accepted request and form its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            data_q  <= '0;
            fault_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            pend_q  <= 1'b1;
            data_q  <= ~req_addr;
            fault_q <= (req_addr >= FAULT_BASE);
        end else begin
            pend_q  <= 1'b0;
        end
    end

    assign rsp_valid = pend_q;
    assign rsp_data  = data_q;
    assign rsp_fault = fault_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)))
        else $error("request dropped or changed while stalled"); // R8
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready))
        else $error("response without an accepted request"); // R8
endmodule

// File: rtl/vldq_bounds.sv
// Range check: flags a vector length outside 1..MAXVL or a register
// window that would run past the end of the register file.
// Assumes: purely combinational, evaluated on the start inputs.
module vldq_bounds #(
    parameter int NREG  = vldq_pkg::NREG_DEF,
    parameter int MAXVL = vldq_pkg::MAXVL_DEF,
    localparam int RIDX_W = $clog2(NREG),
    localparam int VL_W   = $clog2(MAXVL + 1),
    localparam int SW     = RIDX_W + VL_W + 1
) (
    input  logic [VL_W-1:0]   vl,
    input  logic [RIDX_W-1:0] ra,
    input  logic [RIDX_W-1:0] rt,
    output logic              bad
);
    logic [SW-1:0] ra_end;
    logic [SW-1:0] rt_end;

    // Purpose: one past the last register touched on each side.
    assign ra_end = SW'(ra) + SW'(vl);
    assign rt_end = SW'(rt) + SW'(vl);

    // Purpose: combine the length and window checks.
    assign bad = (vl == '0)
              || (vl > VL_W'(MAXVL))
              || (ra_end > SW'(NREG))
              || (rt_end > SW'(NREG));
endmodule

// File: rtl/vldq_seq.sv
// Sequencer: walks the elements of one vector load, one per step,
// issuing a memory request for each enabled element and writing the
// response into the destination window. A fault on element 0 raises
// an exception; a later fault truncates the vector length.
// Assumes: the bounds verdict arrives with start; memory answers after
// one cycle and never stalls a response.
module vldq_seq #(
    parameter int NREG  = vldq_pkg::NREG_DEF,
    parameter int XLEN  = vldq_pkg::XLEN_DEF,
    parameter int MAXVL = vldq_pkg::MAXVL_DEF,
    localparam int RIDX_W = $clog2(NREG),
    localparam int VL_W   = $clog2(MAXVL + 1),
    localparam int MIDX_W = $clog2(MAXVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [MAXVL-1:0]  mask_in,
    input  logic [RIDX_W-1:0] ra_in,
    input  logic [RIDX_W-1:0] rt_in,
    input  logic [XLEN-1:0]   imm_in,
    input  logic              bad_in,
    output logic              busy,
    output logic              done,
    output logic [VL_W-1:0]   vl_out,
    output logic              exc,
    output logic              illegal,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [XLEN-1:0]   req_addr,
    input  logic              rsp_valid,
    input  logic [XLEN-1:0]   rsp_data,
    input  logic              rsp_fault
);
    import vldq_pkg::*;

    seq_state_e        state_q;
    logic [VL_W-1:0]   vl_q;
    logic [VL_W-1:0]   idx_q;
    logic [MAXVL-1:0]  mask_q;
    logic [RIDX_W-1:0] ra_q;
    logic [RIDX_W-1:0] rt_q;
    logic [XLEN-1:0]   imm_q;
    logic [VL_W-1:0]   vl_res_q;
    logic              exc_q;
    logic              ill_q;
    logic              accept;
    logic              at_end;
    logic              elem_on;

    // Purpose: decode the current step.
    assign accept  = (state_q == SQ_IDLE) && start;
    assign at_end  = (idx_q == vl_q);
    assign elem_on = mask_q[idx_q[MIDX_W-1:0]];

    // Purpose: address and destination of the current element.
    assign rf_raddr  = ra_q + RIDX_W'(idx_q);
    assign rf_waddr  = rt_q + RIDX_W'(idx_q);
    assign req_addr  = rf_rdata + imm_q;
    assign req_valid = (state_q == SQ_STEP) && !at_end && elem_on;
    assign rf_we     = (state_q == SQ_WAIT) && rsp_valid && !rsp_fault;
    assign rf_wdata  = rsp_data;

    // Purpose: control FSM, operand latches and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            vl_q     <= '0;
            idx_q    <= '0;
            mask_q   <= '0;
            ra_q     <= '0;
            rt_q     <= '0;
            imm_q    <= '0;
            vl_res_q <= '0;
            exc_q    <= 1'b0;
            ill_q    <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        vl_q     <= vl_in;
                        mask_q   <= mask_in;
                        ra_q     <= ra_in;
                        rt_q     <= rt_in;
                        imm_q    <= imm_in;
                        idx_q    <= '0;
                        exc_q    <= 1'b0;
                        ill_q    <= bad_in;
                        vl_res_q <= vl_in;
                        state_q  <= bad_in ? SQ_FIN : SQ_STEP;
                    end
                end
                SQ_STEP: begin
                    if (at_end) begin
                        vl_res_q <= vl_q;
                        state_q  <= SQ_FIN;
                    end else if (!elem_on) begin
                        idx_q <= idx_q + 1'b1;
                    end else if (req_ready) begin
                        state_q <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_fault) begin
                            if (idx_q == '0) begin
                                exc_q    <= 1'b1;
                                vl_res_q <= vl_q;
                            end else begin
                                vl_res_q <= idx_q;
                            end
                            state_q <= SQ_FIN;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SQ_STEP;
                        end
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign busy    = (state_q != SQ_IDLE);
    assign done    = (state_q == SQ_FIN);
    assign vl_out  = vl_res_q;
    assign exc     = exc_q;
    assign illegal = ill_q;

    // Assertion support: whether the current instruction touched memory
    // or the register file.
    logic req_seen_q;
    logic wr_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_q <= 1'b0;
            wr_seen_q  <= 1'b0;
        end else if (accept) begin
            req_seen_q <= 1'b0;
            wr_seen_q  <= 1'b0;
        end else begin
            if (req_valid && req_ready) req_seen_q <= 1'b1;
            if (rf_we)                  wr_seen_q  <= 1'b1;
        end
    end

    AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!req_seen_q && !wr_seen_q))
        else $error("illegal instruction touched memory"); // R6
    AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc) |-> !wr_seen_q)
        else $error("exception after a register write"); // R4
    AST_VL_NOT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_q))
        else $error("reported length above requested"); // R5
    AST_WRITE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(req_valid && req_ready))
        else $error("register write without memory access"); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R7
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(vl_q) && $stable(imm_q) && $stable(rt_q)))
        else $error("operands changed while busy"); // R9
endmodule

// File: rtl/vldq_ffload.sv
// Top: fault-first vector load block. Ties the range check, sequencer,
// register file and memory model together and arbitrates the register
// write port between the sequencer and the idle-only preload port.
// Assumes: start and preload are driven synchronously to clk.
module vldq_ffload #(
    parameter int NREG  = vldq_pkg::NREG_DEF,
    parameter int XLEN  = vldq_pkg::XLEN_DEF,
    parameter int MAXVL = vldq_pkg::MAXVL_DEF,
    parameter logic [XLEN-1:0] FAULT_BASE = 'h0001_0000,
    localparam int RIDX_W = $clog2(NREG),
    localparam int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [MAXVL-1:0]  mask_in,
    input  logic [RIDX_W-1:0] ra_in,
    input  logic [RIDX_W-1:0] rt_in,
    input  logic [XLEN-1:0]   imm_in,
    input  logic              pre_we,
    input  logic [RIDX_W-1:0] pre_idx,
    input  logic [XLEN-1:0]   pre_data,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              busy,
    output logic              done,
    output logic [VL_W-1:0]   vl_out,
    output logic              exc,
    output logic              illegal
);
    logic              bad;
    logic [RIDX_W-1:0] seq_raddr;
    logic [XLEN-1:0]   seq_rdata;
    logic              seq_we;
    logic [RIDX_W-1:0] seq_waddr;
    logic [XLEN-1:0]   seq_wdata;
    logic              req_valid;
    logic              req_ready;
    logic [XLEN-1:0]   req_addr;
    logic              rsp_valid;
    logic [XLEN-1:0]   rsp_data;
    logic              rsp_fault;
    logic              pre_ok;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;

    vldq_bounds #(.NREG(NREG), .MAXVL(MAXVL)) u_bounds (
        .vl  (vl_in),
        .ra  (ra_in),
        .rt  (rt_in),
        .bad (bad)
    );

    vldq_seq #(.NREG(NREG), .XLEN(XLEN), .MAXVL(MAXVL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl_in     (vl_in),
        .mask_in   (mask_in),
        .ra_in     (ra_in),
        .rt_in     (rt_in),
        .imm_in    (imm_in),
        .bad_in    (bad),
        .busy      (busy),
        .done      (done),
        .vl_out    (vl_out),
        .exc       (exc),
        .illegal   (illegal),
        .rf_raddr  (seq_raddr),
        .rf_rdata  (seq_rdata),
        .rf_we     (seq_we),
        .rf_waddr  (seq_waddr),
        .rf_wdata  (seq_wdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_fault (rsp_fault)
    );

    // Purpose: preload writes land only while no instruction runs.
    assign pre_ok   = pre_we && !busy;
    assign rf_we    = seq_we || pre_ok;
    assign rf_waddr = seq_we ? seq_waddr : pre_idx;
    assign rf_wdata = seq_we ? seq_wdata : pre_data;

    vldq_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (seq_raddr),
        .rdata_a (seq_rdata),
        .raddr_b (rd_idx),
        .rdata_b (rd_data)
    );

    vldq_mem_model #(.XLEN(XLEN), .FAULT_BASE(FAULT_BASE)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_fault (rsp_fault)
    );

    AST_SEQ_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> busy)
        else $error("sequencer write while idle"); // R9
endmodule

// File: tb/vldq_ffload_test.sv
module vldq_ffload_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  vl_in = '0;
    logic [15:0] mask_in = '0;
    logic [4:0]  ra_in = '0;
    logic [4:0]  rt_in = '0;
    logic [31:0] imm_in = '0;
    logic        pre_we = 1'b0;
    logic [4:0]  pre_idx = '0;
    logic [31:0] pre_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        busy, done, exc, illegal;
    logic [4:0]  vl_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    localparam logic [31:0] FB = 32'h0001_0000;

    always #4 clk = ~clk;   // 125 MHz

    vldq_ffload uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .mask_in(mask_in), .ra_in(ra_in), .rt_in(rt_in), .imm_in(imm_in),
        .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done),
        .vl_out(vl_out), .exc(exc), .illegal(illegal)
    );

    typedef struct packed {
        logic [4:0]  vl;
        logic [15:0] mask;
        logic [4:0]  ra;
        logic [4:0]  rt;
        logic [31:0] imm;
        logic [4:0]  pidx;
        logic [31:0] pval;
        logic [4:0]  evl;
        logic        eexc;
        logic        eill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd16, 16'hFFFF, 5'd0,  5'd16, 32'h4,        5'd0, 32'h0,        5'd16, 1'b0, 1'b0},
        '{5'd8,  16'h00A5, 5'd2,  5'd20, 32'h10,       5'd0, 32'h0,        5'd8,  1'b0, 1'b0},
        '{5'd5,  16'h001F, 5'd4,  5'd20, 32'h0,        5'd4, 32'hFFFF0000, 5'd5,  1'b1, 1'b0},
        '{5'd6,  16'h003F, 5'd4,  5'd20, 32'h0,        5'd7, 32'h00020000, 5'd3,  1'b0, 1'b0},
        '{5'd4,  16'h000E, 5'd4,  5'd20, 32'h0,        5'd5, 32'h00020000, 5'd1,  1'b0, 1'b0},
        '{5'd13, 16'hFFFF, 5'd20, 5'd0,  32'h0,        5'd0, 32'h0,        5'd13, 1'b0, 1'b1},
        '{5'd5,  16'h001F, 5'd0,  5'd28, 32'h0,        5'd0, 32'h0,        5'd5,  1'b0, 1'b1},
        '{5'd5,  16'h001F, 5'd0,  5'd27, 32'h0,        5'd0, 32'h0,        5'd5,  1'b0, 1'b0},
        '{5'd0,  16'hFFFF, 5'd0,  5'd0,  32'h0,        5'd0, 32'h0,        5'd0,  1'b0, 1'b1},
        '{5'd17, 16'hFFFF, 5'd0,  5'd0,  32'h0,        5'd0, 32'h0,        5'd17, 1'b0, 1'b1},
        '{5'd4,  16'h000B, 5'd4,  5'd20, 32'h0,        5'd6, 32'hFFFF0000, 5'd4,  1'b0, 1'b0},
        '{5'd3,  16'h0007, 5'd1,  5'd10, 32'hFFFFFF00, 5'd0, 32'h0,        5'd3,  1'b0, 1'b0},
        '{5'd4,  16'h0000, 5'd0,  5'd8,  32'h0,        5'd0, 32'h0,        5'd4,  1'b0, 1'b0}
    };

    logic [31:0] exp_regs [32];
    int          exp_lat;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Writes the base pattern (index * 0x100) and one override, idle only.
    task automatic preload(input logic [4:0] pidx, input logic [31:0] pval);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_idx = 5'(k); pre_data = 32'(k) * 32'h100;
            exp_regs[k] = 32'(k) * 32'h100;
        end
        @(negedge clk);
        pre_idx = pidx; pre_data = pval;
        exp_regs[pidx] = pval;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // Expected registers and latency from the requirements (R1..R7).
    task automatic model(input vec_t v);
        int e = 0;
        bit faulted = 0;
        logic [31:0] ea;
        if (v.eill) begin
            exp_lat = 0;
            return;
        end
        for (int i = 0; i < 32; i++) begin
            if (i >= int'(v.vl) || faulted) break;
            if (!v.mask[i]) begin
                e += 1;
            end else begin
                e += 2;
                ea = exp_regs[5'(int'(v.ra) + i)] + v.imm;
                if (ea >= FB) faulted = 1;
                else exp_regs[5'(int'(v.rt) + i)] = ~ea;
            end
        end
        exp_lat = faulted ? e : e + 1;
    endtask

    task automatic pulse_start(input vec_t v);
        @(negedge clk);
        vl_in = v.vl; mask_in = v.mask; ra_in = v.ra; rt_in = v.rt; imm_in = v.imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 32; k++) begin
            rd_idx = 5'(k);
            #1;
            chk(req, $sformatf("reg%0d", k), rd_data, exp_regs[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        string rq;
        vec_t alt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "busy",    32'(busy),    32'd0);
        chk("R10", "done",    32'(done),    32'd0);
        chk("R10", "exc",     32'(exc),     32'd0);
        chk("R10", "illegal", 32'(illegal), 32'd0);
        chk("R10", "vl_out",  32'(vl_out),  32'd0);
        rd_idx = 5'd5; #1;
        chk("R10", "reg5",    rd_data,      32'd0);

        for (int n = 0; n < NV; n++) begin
            preload(VECS[n].pidx, VECS[n].pval);
            model(VECS[n]);
            pulse_start(VECS[n]);
            wait_done(lat);
            if (VECS[n].eill)                  rq = "R6";
            else if (VECS[n].eexc)             rq = "R4";
            else if (VECS[n].evl < VECS[n].vl) rq = "R5";
            else                               rq = "R1";
            chk(rq,   $sformatf("vec%0d vl_out", n),  32'(vl_out),  32'(VECS[n].evl));
            chk(rq,   $sformatf("vec%0d exc", n),     32'(exc),     32'(VECS[n].eexc));
            chk(rq,   $sformatf("vec%0d illegal", n), 32'(illegal), 32'(VECS[n].eill));
            chk("R7", $sformatf("vec%0d latency", n), 32'(lat),     32'(exp_lat));
            @(negedge clk);
            chk("R7", $sformatf("vec%0d done pulse", n), 32'(done), 32'd0);
            // R2 R3 R8 register contents
            check_regs({rq, " R2 R3 R8"});
        end

        // R9: start and preload ignored while busy
        preload(5'd0, 32'h0);
        model(VECS[0]);
        pulse_start(VECS[0]);
        repeat (3) @(negedge clk);
        alt = VECS[8];
        alt.vl = 5'd1; alt.rt = 5'd1;
        vl_in = alt.vl; rt_in = alt.rt; start = 1'b1;
        pre_we = 1'b1; pre_idx = 5'd3; pre_data = 32'hDEAD_BEEF;
        @(negedge clk);
        start = 1'b0; pre_we = 1'b0;
        lat = 4;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", "vl_out busy start", 32'(vl_out), 32'd16);
        chk("R9", "latency busy start", 32'(lat), 32'(exp_lat));
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "no second done", 32'(done), 32'd0);
        check_regs("R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule